// File: doc/BRIEF.md
# Run-Time Length-Selectable Two-Pass FFT Address Sequencer

This block orders the work for an FFT whose length is picked at run time. A transform of N points is split into a first pass of L-point transforms and a second pass of S-point transforms, with N = L·S. The sample buffer, the two butterfly engines, the complex multiplier and the twiddle ROM are all outside the block. The sequencer only produces the addresses, strobes, start pulses and indices that move data between them. The buffer holds 16-bit fixed-point complex samples. Buffer address `S·a + b` holds input sample `a·S + b`, so the buffer can be seen as an L×S matrix.

In the first pass the block walks the matrix one column at a time. It reads L samples into engine one. It waits for that engine to finish, then writes the L results back in place, each tagged with the twiddle exponent the multiplier needs. The second pass walks the matrix one row at a time. It reads S scaled values into engine two, waits for it to finish, then labels each result with its position in the natural-order spectrum. A 2-bit mode, sampled when the run starts, sets L and S.

Top module: `fft2d_seq`

## Requirements
- R1: The mode sets the split and the `eng1_lg`/`eng2_lg` outputs (log2 of L and S): 00 gives 8×8 (3,3), 01 gives 64×2 (6,1), 10 gives 64×8 (6,3), 11 gives 64×16 (6,4). One run makes exactly 2N read strobes, N write strobes and N output strobes.
- R2: First-pass reads go column by column, with b rising from 0 to S−1. Each column makes L reads at address S·i+b, with i rising. `eng1_start` is high in the cycle of each column's first read, so a run has S such pulses.
- R3: After `eng1_done`, the block makes L write strobes at address S·k+b, with k rising. Each carries `tw_idx` = (k·b) mod N.
- R4: Each column's write-back ends before the next column's reads begin, and every first-pass write comes before the first second-pass read. No read, write or output strobe occurs while the block waits for an engine's done. At most one of the three strobes is high in any cycle.
- R5: Second-pass reads go row by row, with k1 rising from 0 to L−1. Each row makes S reads at address S·k1+j, with j rising. `eng2_start` is high with each row's first read, so a run has L such pulses.
- R6: After `eng2_done`, the block makes S output strobes with `out_idx` = k1 + L·k2, with k2 rising. This index is the result's natural-order bin number.
- R7: `done` is high for exactly one cycle, in the cycle after the last output strobe, and `busy` is low in that cycle.
- R8: `start` is taken only while `busy` is low. `mode` is sampled in that cycle, and `busy` is high from the next cycle. While `busy` is high, `start` and `mode` have no effect on any address, index, strobe count or on `done`.
- R9: During and after reset, `busy`, `done`, the three strobes and both engine starts are low. They stay low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transform run |
| mode | input | 2 | Transform length select |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| eng1_lg | output | 4 | log2 of first-pass length L |
| eng1_start | output | 1 | Start first-pass engine |
| eng1_done | input | 1 | First-pass engine finished |
| eng2_lg | output | 4 | log2 of second-pass length S |
| eng2_start | output | 1 | Start second-pass engine |
| eng2_done | input | 1 | Second-pass engine finished |
| rd_valid | output | 1 | Buffer read strobe |
| rd_addr | output | 10 | Buffer read address |
| wr_valid | output | 1 | Buffer write strobe |
| wr_addr | output | 10 | Buffer write address |
| tw_idx | output | 10 | Twiddle exponent for the value being written |
| out_valid | output | 1 | Result strobe |
| out_idx | output | 10 | Natural-order bin of the result |

## Verification
The hardest case to reach is a second `start`, carrying a different mode, that arrives in the middle of a run. It would only show up if the block reloaded its length or restarted its counters partway through a pass. The bench raises `start` with the opposite mode about forty cycles into a 128-point run, which lands during first-pass traffic. It then requires the whole read, write and output streams to match an unbroken 128-point run, with exactly one `done`. Engine models answer each start only after a fixed delay, so the wait states are long enough to catch any stray strobe.

// File: rtl/fft2d_seq_pkg.sv
package fft2d_seq_pkg;

   // width of a log2-length field
   localparam int unsigned LGW = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_S1_RD,
      ST_S1_WAIT,
      ST_S1_WR,
      ST_S2_RD,
      ST_S2_WAIT,
      ST_S2_OUT
   } seq_state_t;

   typedef struct packed {
      logic [LGW-1:0] lg_a;   // log2 of first-pass length
      logic [LGW-1:0] lg_b;   // log2 of second-pass length
   } split_cfg_t;

endpackage

// File: rtl/fft2d_mode_dec.sv
module fft2d_mode_dec
   import fft2d_seq_pkg::*;
#(
   parameter int unsigned     AW      = 10,
   parameter logic [4*LGW-1:0] LG1_TAB = {4'd6, 4'd6, 4'd6, 4'd3},
   parameter logic [4*LGW-1:0] LG2_TAB = {4'd4, 4'd3, 4'd1, 4'd3}
) (
   input  logic [1:0]  mode,
   output split_cfg_t  cfg
);

   // every table entry must be a real split that fits the address range
   for (genvar m = 0; m < 4; m++) begin : g_tab_chk
      localparam int unsigned LA = int'(LG1_TAB[m*LGW +: LGW]);
      localparam int unsigned LB = int'(LG2_TAB[m*LGW +: LGW]);
      if (LA < 1 || LB < 1) begin : g_zero
         $error("fft2d_mode_dec: zero-length pass in mode table");
      end
      if (LA + LB > AW) begin : g_wide
         $error("fft2d_mode_dec: mode table exceeds address width");
      end
   end

   always_comb begin
      cfg.lg_a = LG1_TAB[int'(mode)*LGW +: LGW];
      cfg.lg_b = LG2_TAB[int'(mode)*LGW +: LGW];
   end

endmodule

// File: rtl/fft2d_idx_cnt.sv
module fft2d_idx_cnt #(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_step,
   input  logic          out_step,
   input  logic [AW-1:0] in_max,
   input  logic [AW-1:0] out_max,
   output logic [AW-1:0] inner,
   output logic [AW-1:0] outer,
   output logic          in_last,
   output logic          out_last
);

   assign in_last  = (inner == in_max);
   assign out_last = (outer == out_max);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inner <= '0;
         outer <= '0;
      end else if (clr) begin
         inner <= '0;
         outer <= '0;
      end else begin
         if (in_step) begin
            inner <= in_last ? '0 : inner + AW'(1);
         end
         if (out_step) begin
            outer <= out_last ? '0 : outer + AW'(1);
         end
      end
   end

endmodule

// File: rtl/fft2d_addr_gen.sv
module fft2d_addr_gen
   import fft2d_seq_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic           ph2,
   input  logic [LGW-1:0] lg_a,
   input  logic [LGW-1:0] lg_b,
   input  logic [AW-1:0]  inner,
   input  logic [AW-1:0]  outer,
   output logic [AW-1:0]  buf_addr,
   output logic [AW-1:0]  tw_idx,
   output logic [AW-1:0]  out_idx
);

   logic [AW-1:0]  col_walk;
   logic [AW-1:0]  row_walk;
   logic [AW-1:0]  len_mask;
   logic [LGW:0]   lg_sum;

   always_comb begin
      // pass one: inner is the row, outer the column
      col_walk = (inner << lg_b) | outer;
      // pass two: outer is the row, inner the column
      row_walk = (outer << lg_b) | inner;
      buf_addr = ph2 ? row_walk : col_walk;

      lg_sum   = {1'b0, lg_a} + {1'b0, lg_b};
      len_mask = ~({AW{1'b1}} << lg_sum);
      tw_idx   = (inner * outer) & len_mask;

      out_idx  = outer | (inner << lg_a);
   end

endmodule

// File: rtl/fft2d_seq.sv
module fft2d_seq
   import fft2d_seq_pkg::*;
#(
   parameter int unsigned      AW      = 10,
   parameter logic [4*LGW-1:0] LG1_TAB = {4'd6, 4'd6, 4'd6, 4'd3},
   parameter logic [4*LGW-1:0] LG2_TAB = {4'd4, 4'd3, 4'd1, 4'd3}
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [1:0]     mode,
   output logic           busy,
   output logic           done,
   output logic [LGW-1:0] eng1_lg,
   output logic           eng1_start,
   input  logic           eng1_done,
   output logic [LGW-1:0] eng2_lg,
   output logic           eng2_start,
   input  logic           eng2_done,
   output logic           rd_valid,
   output logic [AW-1:0]  rd_addr,
   output logic           wr_valid,
   output logic [AW-1:0]  wr_addr,
   output logic [AW-1:0]  tw_idx,
   output logic           out_valid,
   output logic [AW-1:0]  out_idx
);

   if (AW < 2) begin : g_aw_chk
      $error("fft2d_seq: address width too small");
   end

   seq_state_t    st, st_nx;
   split_cfg_t    cfg_dec, cfg_q;
   logic          accept;
   logic          ph2;
   logic          in_step, out_step;
   logic          in_last, out_last;
   logic [AW-1:0] inner, outer;
   logic [AW-1:0] in_max, out_max;
   logic [AW-1:0] len_a_m1, len_b_m1;
   logic [AW-1:0] buf_addr;
   logic          fin;
   logic          done_q;

   fft2d_mode_dec #(
      .AW      (AW),
      .LG1_TAB (LG1_TAB),
      .LG2_TAB (LG2_TAB)
   ) i_mode_dec (
      .mode (mode),
      .cfg  (cfg_dec)
   );

   fft2d_idx_cnt #(
      .AW (AW)
   ) i_idx_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .in_step  (in_step),
      .out_step (out_step),
      .in_max   (in_max),
      .out_max  (out_max),
      .inner    (inner),
      .outer    (outer),
      .in_last  (in_last),
      .out_last (out_last)
   );

   fft2d_addr_gen #(
      .AW (AW)
   ) i_addr_gen (
      .ph2      (ph2),
      .lg_a     (cfg_q.lg_a),
      .lg_b     (cfg_q.lg_b),
      .inner    (inner),
      .outer    (outer),
      .buf_addr (buf_addr),
      .tw_idx   (tw_idx),
      .out_idx  (out_idx)
   );

   always_comb begin
      accept   = start && (st == ST_IDLE);
      ph2      = (st == ST_S2_RD) || (st == ST_S2_WAIT) || (st == ST_S2_OUT);
      len_a_m1 = (AW'(1) << cfg_q.lg_a) - AW'(1);
      len_b_m1 = (AW'(1) << cfg_q.lg_b) - AW'(1);
      in_max   = ph2 ? len_b_m1 : len_a_m1;
      out_max  = ph2 ? len_a_m1 : len_b_m1;

      in_step  = (st == ST_S1_RD) || (st == ST_S1_WR) ||
                 (st == ST_S2_RD) || (st == ST_S2_OUT);
      out_step = ((st == ST_S1_WR) || (st == ST_S2_OUT)) && in_last;
      fin      = (st == ST_S2_OUT) && in_last && out_last;

      st_nx = st;
      case (st)
         ST_IDLE:    if (accept)    st_nx = ST_S1_RD;
         ST_S1_RD:   if (in_last)   st_nx = ST_S1_WAIT;
         ST_S1_WAIT: if (eng1_done) st_nx = ST_S1_WR;
         ST_S1_WR:   if (in_last)   st_nx = out_last ? ST_S2_RD : ST_S1_RD;
         ST_S2_RD:   if (in_last)   st_nx = ST_S2_WAIT;
         ST_S2_WAIT: if (eng2_done) st_nx = ST_S2_OUT;
         ST_S2_OUT:  if (in_last)   st_nx = out_last ? ST_IDLE : ST_S2_RD;
         default:                   st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cfg_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st     <= st_nx;
         done_q <= fin;
         if (accept) begin
            cfg_q <= cfg_dec;
         end
      end
   end

   always_comb begin
      busy       = (st != ST_IDLE);
      done       = done_q;
      eng1_lg    = cfg_q.lg_a;
      eng2_lg    = cfg_q.lg_b;
      rd_valid   = (st == ST_S1_RD) || (st == ST_S2_RD);
      wr_valid   = (st == ST_S1_WR);
      out_valid  = (st == ST_S2_OUT);
      eng1_start = (st == ST_S1_RD) && (inner == '0);
      eng2_start = (st == ST_S2_RD) && (inner == '0);
      rd_addr    = buf_addr;
      wr_addr    = buf_addr;
   end

endmodule

// File: rtl/fft2d_seq_chk.sv
module fft2d_seq_chk
   import fft2d_seq_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [1:0]     mode,
   input logic           busy,
   input logic           done,
   input logic [LGW-1:0] eng1_lg,
   input logic           eng1_start,
   input logic           eng1_done,
   input logic [LGW-1:0] eng2_lg,
   input logic           eng2_start,
   input logic           eng2_done,
   input logic           rd_valid,
   input logic [AW-1:0]  rd_addr,
   input logic           wr_valid,
   input logic [AW-1:0]  wr_addr,
   input logic [AW-1:0]  tw_idx,
   input logic           out_valid,
   input logic [AW-1:0]  out_idx
);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(rd_valid || wr_valid || out_valid || eng1_start || eng2_start));

   // R4
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, wr_valid, out_valid}));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(out_valid) && !busy));

   // R8
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(eng1_lg) && $stable(eng2_lg)));

   // R2
   eng1_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng1_start |-> (rd_valid && !eng2_start));

   // R5
   eng2_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng2_start |-> (rd_valid && !eng1_start));

endmodule

bind fft2d_seq fft2d_seq_chk #(.AW(AW)) i_fft2d_seq_chk (.*);

// File: tb/test_fft2d_seq.sv
module test_fft2d_seq;

   logic       clk;
   logic       rst_n;
   logic       start;
   logic [1:0] mode;
   logic       busy, done;
   logic [3:0] eng1_lg, eng2_lg;
   logic       eng1_start, eng1_done, eng2_start, eng2_done;
   logic       rd_valid, wr_valid, out_valid;
   logic [9:0] rd_addr, wr_addr, tw_idx, out_idx;

   int n_chk  = 0;
   int n_fail = 0;
   int cur_l  = 8;
   int cur_s  = 8;
   int cnt1   = 0;
   int cnt2   = 0;
   int wait_viol = 0;

   int exp_rd  [0:2047];
   int exp_wr  [0:1023];
   int exp_tw  [0:1023];
   int exp_out [0:1023];

   fft2d_seq i_fft2d_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .busy       (busy),
      .done       (done),
      .eng1_lg    (eng1_lg),
      .eng1_start (eng1_start),
      .eng1_done  (eng1_done),
      .eng2_lg    (eng2_lg),
      .eng2_start (eng2_start),
      .eng2_done  (eng2_done),
      .rd_valid   (rd_valid),
      .rd_addr    (rd_addr),
      .wr_valid   (wr_valid),
      .wr_addr    (wr_addr),
      .tw_idx     (tw_idx),
      .out_valid  (out_valid),
      .out_idx    (out_idx)
   );

   initial begin
      clk = 1'b0;
      forever #4 clk = ~clk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // engine models: done arrives a fixed time after each start; any strobe
   // inside the waiting window is recorded (R4)
   initial begin
      eng1_done = 1'b0;
      eng2_done = 1'b0;
      forever begin
         @(negedge clk);
         eng1_done = 1'b0;
         eng2_done = 1'b0;
         if (!eng1_start && cnt1 >= 1 && cnt1 <= 4 &&
             (rd_valid || wr_valid || out_valid)) wait_viol++;
         if (!eng2_start && cnt2 >= 1 && cnt2 <= 4 &&
             (rd_valid || wr_valid || out_valid)) wait_viol++;
         if (eng1_start) cnt1 = cur_l + 3;
         else if (cnt1 > 0) begin
            cnt1--;
            if (cnt1 == 0) eng1_done = 1'b1;
         end
         if (eng2_start) cnt2 = cur_s + 3;
         else if (cnt2 > 0) begin
            cnt2--;
            if (cnt2 == 0) eng2_done = 1'b1;
         end
      end
   end

   task automatic check_reset();
      rst_n = 1'b0;
      start = 1'b0;
      mode  = 2'b00;
      repeat (3) @(negedge clk);
      // R9: during reset
      chk(!busy && !done, "R9", "busy/done in reset", int'({busy, done}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R9: idle after reset
      chk(!busy && !done, "R9", "busy/done idle", int'({busy, done}), 0);
      chk(!rd_valid && !wr_valid && !out_valid && !eng1_start && !eng2_start,
          "R9", "strobes idle",
          int'({rd_valid, wr_valid, out_valid, eng1_start, eng2_start}), 0);
   endtask

   task automatic run_case(input logic [1:0] m, input bit disturb);
      int L, S, N, LA, LB;
      int ri = 0, wi = 0, oi = 0, e1 = 0, e2 = 0;
      int rmis1 = 0, rmis2 = 0, wmis = 0, tmis = 0, omis = 0;
      int ra = 0, re = 0, wa = 0, we = 0, ta = 0, te = 0, oa = 0, oe = 0;
      int early = 0, last_out = -1, done_cyc = -1, done_cnt = 0;
      int busy_in_done = 0;
      int k;
      case (m)
         2'b00:   begin L = 8;  S = 8;  LA = 3; LB = 3; end
         2'b01:   begin L = 64; S = 2;  LA = 6; LB = 1; end
         2'b10:   begin L = 64; S = 8;  LA = 6; LB = 3; end
         default: begin L = 64; S = 16; LA = 6; LB = 4; end
      endcase
      N = L * S;
      k = 0;
      for (int b = 0; b < S; b++)
         for (int i = 0; i < L; i++) begin
            exp_rd[k] = S * i + b;
            exp_wr[k] = S * i + b;
            exp_tw[k] = (i * b) % N;
            k++;
         end
      for (int r = 0; r < L; r++)
         for (int j = 0; j < S; j++) begin
            exp_rd[N + r * S + j] = S * r + j;
            exp_out[r * S + j]    = r + L * j;
         end
      cur_l = L;
      cur_s = S;
      wait_viol = 0;

      @(negedge clk);
      mode  = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R8, R1: first cycle after accept
      chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
      chk(int'(eng1_lg) == LA && int'(eng2_lg) == LB, "R1", "stage log2 lengths",
          int'(eng1_lg) * 16 + int'(eng2_lg), LA * 16 + LB);

      for (int c = 0; c < 20000; c++) begin
         if (rd_valid) begin
            if (ri < 2 * N) begin
               if (int'(rd_addr) != exp_rd[ri]) begin
                  if (ri < N) rmis1++; else rmis2++;
                  if (rmis1 + rmis2 == 1) begin ra = int'(rd_addr); re = exp_rd[ri]; end
               end
               if (ri >= N && wi != N) early++;
            end
            ri++;
         end
         if (wr_valid) begin
            if (wi < N) begin
               if (int'(wr_addr) != exp_wr[wi]) begin
                  wmis++;
                  if (wmis == 1) begin wa = int'(wr_addr); we = exp_wr[wi]; end
               end
               if (int'(tw_idx) != exp_tw[wi]) begin
                  tmis++;
                  if (tmis == 1) begin ta = int'(tw_idx); te = exp_tw[wi]; end
               end
            end
            wi++;
         end
         if (out_valid) begin
            if (oi < N && int'(out_idx) != exp_out[oi]) begin
               omis++;
               if (omis == 1) begin oa = int'(out_idx); oe = exp_out[oi]; end
            end
            oi++;
            last_out = c;
         end
         if (eng1_start) e1++;
         if (eng2_start) e2++;
         if (done) begin
            done_cnt++;
            if (done_cyc < 0) done_cyc = c;
            if (busy) busy_in_done++;
         end
         if (done_cyc >= 0 && c >= done_cyc + 3) break;
         // R8: second request with another mode in mid-run
         if (disturb && c == 40) begin mode = ~m; start = 1'b1; end
         if (disturb && c == 41) begin start = 1'b0; mode = m; end
         @(negedge clk);
      end

      chk(ri == 2 * N, "R1", "read strobe count", ri, 2 * N);
      chk(wi == N, "R1", "write strobe count", wi, N);
      chk(oi == N, "R1", "output strobe count", oi, N);
      chk(rmis1 == 0, "R2", "first-pass read address", ra, re);
      chk(e1 == S, "R2", "eng1_start pulses", e1, S);
      chk(wmis == 0, "R3", "write-back address", wa, we);
      chk(tmis == 0, "R3", "twiddle exponent", ta, te);
      chk(early == 0 && wait_viol == 0, "R4", "ordering/wait violations",
          early + wait_viol, 0);
      chk(rmis2 == 0, "R5", "second-pass read address", ra, re);
      chk(e2 == L, "R5", "eng2_start pulses", e2, L);
      chk(omis == 0, "R6", "output index", oa, oe);
      chk(done_cnt == 1, "R7", "done pulse count", done_cnt, 1);
      chk(done_cyc == last_out + 1, "R7", "done cycle", done_cyc, last_out + 1);
      chk(busy_in_done == 0, "R7", "busy during done", busy_in_done, 0);
      if (disturb)
         chk(rmis1 + rmis2 + wmis + tmis + omis == 0 && done_cnt == 1, "R8",
             "streams with start while busy", rmis1 + rmis2 + wmis + tmis + omis, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      check_reset();
      run_case(2'b01, 1'b0);
      run_case(2'b00, 1'b0);
      run_case(2'b10, 1'b0);
      run_case(2'b11, 1'b0);
      run_case(2'b01, 1'b1);
      run_case(2'b00, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule